// File: doc/BRIEF.md
# Two-Wire Slave Byte Engine with Clock Holding

This block is the byte-level data path of a slave on a two-wire serial bus (I2C or SMBus style). On the bus side it samples the clock and data lines, recognises START and STOP conditions and compares a 7-bit address. It shifts bytes in or out and answers with acknowledge bits. Both lines are driven only as open-drain pull-down enables. On the processor side it offers one shared data register, a status-read strobe and the flags transmit-empty, receive-full, byte-finished, overrun and underrun.

At every byte boundary the engine checks whether the data register can supply or accept a byte. If it cannot and clock holding is enabled, the engine keeps the clock line low. It lets go only after software reads the status and then accesses the data register. If holding is disabled, the engine does not wait. On receive it drops the new byte and flags overrun. On transmit it sends the previous byte again and flags underrun. Master mode, arbitration, timeouts, packet error checking and alert signalling are not part of this block.

Top module: `twi_slave_byte`

## Requirements
- R1: After reset both pull enables are 0, `addressed` is 0, `txe` is 1 and `rxne`, `btf`, `ovr`, `udr` are 0. START is data falling while the clock is high. STOP is data rising while the clock is high. After a STOP, `addressed` is 0.
- R2: The first byte after START is taken MSB first. Its upper seven bits are compared with `own_addr`. On a match the engine pulls data low on the ninth clock (ACK). On a mismatch it leaves data released (NACK) and ignores the bus until the next START.
- R3: Bit 0 of the address byte selects the direction. 0 means the master writes (`is_tx` = 0) and 1 means the master reads (`is_tx` = 1).
- R4: Each received byte is ACKed. If the data register is empty, the byte goes into the register and `rxne` is set. A `cpu_rd` pulse clears `rxne`, and `cpu_rdata` shows the register contents.
- R5: A byte may finish arriving while `rxne` is 1 with `stretch_en` = 1. The engine then sets `btf`, pulls the clock low and keeps the new byte in the shifter. It releases after a `stat_rd` pulse followed by a `cpu_rd` pulse. At that point the held byte enters the register (`rxne` = 1), `btf` clears and the ACK completes.
- R6: During a hold, a data register access with no `stat_rd` before it does not release the clock line.
- R7: With `stretch_en` = 0, a byte that finishes while `rxne` is 1 sets `ovr`. That byte is discarded, the register keeps the older byte and the clock is never held.
- R8: When the master reads and the register holds a byte (`txe` = 0), that byte moves to the shifter at the byte boundary, `txe` becomes 1 and the bits go out MSB first.
- R9: The register may be empty at a transmit boundary with `stretch_en` = 1. The engine then sets `btf` and holds the clock. A `stat_rd` followed by a `cpu_wr` releases it, and the byte from that write is sent. Any earlier write made during the hold is superseded.
- R10: With `stretch_en` = 0, an empty register at a transmit boundary sets `udr` and the previously sent byte is sent again.
- R11: A NACK from the master after a transmitted byte ends the transfer. Data is released, `addressed` falls and further clocks are ignored until a START.
- R12: A `stat_rd` pulse clears `ovr` and `udr`.
- R13: A `cpu_wr` during a byte that is being shifted out is not flagged and does not change that byte. The written value waits in the register for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Slave address |
| stretch_en | input | 1 | 1 enables clock holding |
| cpu_wr | input | 1 | Data register write strobe |
| cpu_wdata | input | 8 | Data register write value |
| cpu_rd | input | 1 | Data register read strobe |
| cpu_rdata | output | 8 | Data register contents |
| stat_rd | input | 1 | Status read strobe |
| txe | output | 1 | Data register empty for transmit |
| rxne | output | 1 | Data register holds an unread byte |
| btf | output | 1 | Byte finished, clock held |
| ovr | output | 1 | Overrun flag |
| udr | output | 1 | Underrun flag |
| addressed | output | 1 | Engine is in an addressed transfer |
| is_tx | output | 1 | Addressed transfer is a master read |

## Verification
The hardest situation to reach is a clock hold in which the processor accesses in the wrong order. It only exists while the bench's bus master has released the clock and is waiting on a line that the engine holds low. The bench model of the master therefore splits every byte from its acknowledge bit. It inspects the pull enable in that gap, then issues a bare register access before the status strobe and confirms that the hold survives. Randomised read transfers enter this hold at every byte after the first, and each release goes through the correct strobe sequence.

// File: rtl/twi_pkg.sv
// Package: shared types of the two-wire slave byte engine.
package twi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, waiting for START
        ST_ADDR,   // shifting the address byte
        ST_AACK,   // driving ACK for the address
        ST_RX,     // shifting a received data byte
        ST_RACK,   // driving ACK for a received byte
        ST_TX,     // shifting a byte out
        ST_TACK    // sampling the master's ACK/NACK
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Module: twi_line_sync
// Brings asynchronous bus lines into the clk domain through a chain of
// flip-flops and keeps one further delayed copy for edge detection.
// Assumes idle lines are high, so every stage resets to 1.
module twi_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] last_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;
        // Shift the line level through the synchroniser and history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], raw_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
        assign last_o[g] = chain[STAGES];
    end
endmodule

// File: rtl/twi_data_reg.sv
// Module: twi_data_reg
// The single processor-visible data register shared by both directions,
// with its empty/full flags. Engine events in the same cycle take
// precedence over processor strobes.
module twi_data_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          rx_put,
    input  logic [DW-1:0] rx_data,
    input  logic          tx_take,
    output logic [DW-1:0] dbuf,
    output logic          txe,
    output logic          rxne
);
    // Update register contents and flags from processor and engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbuf <= '0;
            txe  <= 1'b1;
            rxne <= 1'b0;
        end else begin
            if (cpu_wr) begin
                dbuf <= cpu_wdata;
                txe  <= 1'b0;
            end
            if (cpu_rd)  rxne <= 1'b0;
            if (rx_put) begin
                dbuf <= rx_data;
                rxne <= 1'b1;
            end
            if (tx_take) txe <= 1'b1;
        end
    end
endmodule

// File: rtl/twi_slave_byte.sv
// Module: twi_slave_byte
// Slave-side byte engine of a two-wire bus: START/STOP detection, 7-bit
// address match, byte shifting with ACK, and clock holding or
// overrun/underrun flagging at byte boundaries.
// Assumes the system clock is many times faster than the bus clock and
// that the lines are wired-AND with external pull-ups.
module twi_slave_byte
    import twi_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_pull,
    output logic          sda_pull,
    input  logic [DW-2:0] own_addr,
    input  logic          stretch_en,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rdata,
    input  logic          stat_rd,
    output logic          txe,
    output logic          rxne,
    output logic          btf,
    output logic          ovr,
    output logic          udr,
    output logic          addressed,
    output logic          is_tx
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DW);
    localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

    logic [1:0]    ln_s, ln_d;
    logic          scl_s, sda_s, scl_d, sda_d;
    logic          scl_rise, scl_fall, start_c, stop_c, bus_evt;
    twi_state_e    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh, txbyte, dbuf;
    logic          rw, hold, armed, nack, tx_bit;
    logic          rel_rx, rel_tx, tx_bound, rx_put, tx_take;

    twi_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({sda_i, scl_i}),
        .sync_o(ln_s), .last_o(ln_d)
    );

    assign scl_s    = ln_s[0];
    assign sda_s    = ln_s[1];
    assign scl_d    = ln_d[0];
    assign sda_d    = ln_d[1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
    assign bus_evt  = start_c | stop_c;

    // Release conditions of a hold and data movement at byte boundaries.
    assign rel_rx   = hold & armed & cpu_rd & (state == ST_RACK) & ~bus_evt;
    assign rel_tx   = hold & armed & cpu_wr & (state == ST_TX) & ~bus_evt;
    assign tx_bound = scl_fall & ~hold & ~bus_evt &
                      (((state == ST_AACK) & rw) | ((state == ST_TACK) & ~nack));
    assign tx_take  = (tx_bound & ~txe) | rel_tx;
    assign rx_put   = (scl_fall & ~hold & ~bus_evt & (state == ST_RX) &
                       (cnt == CNT_FULL) & ~rxne) | rel_rx;

    twi_data_reg #(.DW(DW)) u_dreg (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .rx_put(rx_put), .rx_data(sh), .tx_take(tx_take),
        .dbuf(dbuf), .txe(txe), .rxne(rxne)
    );

    // Select the outgoing bit for the current position, MSB first.
    always_comb begin
        tx_bit = 1'b1;
        for (int i = 0; i < DW; i++)
            if (cnt == CW'(DW - 1 - i)) tx_bit = txbyte[i];
    end

    // Bus-side sequencing, shifting, holding and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            txbyte <= '0;
            rw     <= 1'b0;
            hold   <= 1'b0;
            armed  <= 1'b0;
            nack   <= 1'b0;
            ovr    <= 1'b0;
            udr    <= 1'b0;
        end else begin
            if (stat_rd) begin
                ovr <= 1'b0;
                udr <= 1'b0;
                if (hold) armed <= 1'b1;
            end
            if (tx_take) txbyte <= rel_tx ? cpu_wdata : dbuf;
            if (start_c) begin
                state <= ST_ADDR;
                cnt   <= '0;
                hold  <= 1'b0;
                armed <= 1'b0;
            end else if (stop_c) begin
                state <= ST_IDLE;
                hold  <= 1'b0;
                armed <= 1'b0;
            end else if (hold) begin
                if (rel_rx || rel_tx) begin
                    hold  <= 1'b0;
                    armed <= 1'b0;
                end
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise && cnt != CNT_FULL) begin
                            sh  <= {sh[DW-2:0], sda_s};
                            cnt <= cnt + CW'(1);
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            if (state == ST_ADDR) begin
                                if (sh[DW-1:1] == own_addr) begin
                                    state <= ST_AACK;
                                    rw    <= sh[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state <= ST_RACK;
                                if (rxne) begin
                                    if (stretch_en) hold <= 1'b1;
                                    else            ovr  <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_AACK: if (scl_fall) begin
                        cnt   <= '0;
                        state <= rw ? ST_TX : ST_RX;
                        if (rw && txe) begin
                            if (stretch_en) hold <= 1'b1;
                            else            udr  <= 1'b1;
                        end
                    end
                    ST_RACK: if (scl_fall) begin
                        cnt   <= '0;
                        state <= ST_RX;
                    end
                    ST_TX: if (scl_fall) begin
                        if (cnt == CNT_LAST) state <= ST_TACK;
                        else                 cnt   <= cnt + CW'(1);
                    end
                    ST_TACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_TX;
                                cnt   <= '0;
                                if (txe) begin
                                    if (stretch_en) hold <= 1'b1;
                                    else            udr  <= 1'b1;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_pull  = hold;
    assign btf       = hold;
    assign sda_pull  = (state == ST_AACK) | (state == ST_RACK) |
                       ((state == ST_TX) & ~tx_bit);
    assign cpu_rdata = dbuf;
    assign addressed = (state != ST_IDLE) & (state != ST_ADDR);
    assign is_tx     = addressed & rw;
endmodule

// File: rtl/twi_slave_byte_chk.sv
// Module: twi_slave_byte_chk
// Temporal checks on the slave byte engine, attached by bind.
// Assumes stretch_en is held steady while a transfer is in progress.
module twi_slave_byte_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_pull,
    input logic sda_pull,
    input logic stretch_en,
    input logic ovr,
    input logic udr,
    input logic cpu_wr,
    input logic cpu_rd,
    input logic bus_evt,
    input logic scl_s
);
    // A hold only begins while holding is enabled (R5, R9).
    assert_hold_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> stretch_en);

    // A hold ends only after a data register access or a bus condition (R6).
    assert_release_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pull) |-> $past(cpu_wr || cpu_rd || bus_evt));

    // Overrun is raised only when holding is disabled (R7).
    assert_ovr_without_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> !stretch_en);

    // Underrun is raised only when holding is disabled (R10).
    assert_udr_without_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr) |-> !stretch_en);

    // Data drive changes only while the clock is low, apart from START/STOP (R8).
    assert_sda_moves_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> (!scl_s || $past(bus_evt)));
endmodule

bind twi_slave_byte twi_slave_byte_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .stretch_en(stretch_en), .ovr(ovr), .udr(udr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .bus_evt(bus_evt), .scl_s(scl_s)
);

// File: tb/twi_slave_byte_tb.sv
// Bench for twi_slave_byte: a bus master model plus processor strobes,
// with directed corner cases and seeded random transfers.
module twi_slave_byte_tb;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_i, sda_i, scl_pull, sda_pull;
    logic       stretch_en = 1'b1;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, stat_rd = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic       txe, rxne, btf, ovr, udr, addressed, is_tx;
    int         n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    assign scl_i = m_scl & ~scl_pull;
    assign sda_i = m_sda & ~sda_pull;

    twi_slave_byte u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(OWN),
        .stretch_en(stretch_en), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .stat_rd(stat_rd),
        .txe(txe), .rxne(rxne), .btf(btf), .ovr(ovr), .udr(udr),
        .addressed(addressed), .is_tx(is_tx)
    );

    function automatic logic exp_ack(input logic [6:0] a);
        return (a == OWN) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_i) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; qwait(); m_scl = 1'b1; wait_high(); qwait();
        m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; qwait(); m_scl = 1'b1; wait_high(); qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic m_bit_w(input logic b);
        m_sda = b; qwait(); m_scl = 1'b1; wait_high(); qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic m_bit_r(output logic b);
        m_sda = 1'b1; qwait(); m_scl = 1'b1; wait_high(); qwait();
        b = sda_i; qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic m_byte_w(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
    endtask

    task automatic m_byte_r(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_bit_r(b); v[i] = b; end
    endtask

    task automatic cpu_write(input logic [7:0] v);
        @(negedge clk); cpu_wr = 1'b1; cpu_wdata = v;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(output logic [7:0] v);
        @(negedge clk); v = cpu_rdata; cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic stat_pulse();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // Random master-write transfer with a possibly foreign address.
    task automatic rand_write();
        logic [6:0] a;
        logic [7:0] d, got;
        logic       ack;
        int         nb;
        a  = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(0, 127)) : OWN;
        nb = $urandom_range(1, 3);
        m_start();
        m_byte_w({a, 1'b0});
        m_bit_r(ack);
        chk("R2 random address ack", ack, exp_ack(a));
        if (a == OWN) begin
            for (int k = 0; k < nb; k++) begin
                d = 8'($urandom_range(0, 255));
                m_byte_w(d);
                m_bit_r(ack);
                chk("R4 random byte ack", ack, 0);
                chk("R4 random rxne", rxne, 1);
                cpu_read(got);
                chk("R4 random data", got, d);
            end
        end
        m_stop();
    endtask

    // Random master-read transfer; bytes after the first go through a hold.
    task automatic rand_read();
        logic [7:0] d, got;
        logic       ack;
        int         nb;
        nb = $urandom_range(1, 3);
        d  = 8'($urandom_range(0, 255));
        cpu_write(d);
        m_start();
        m_byte_w({OWN, 1'b1});
        m_bit_r(ack);
        chk("R3 random read ack", ack, 0);
        for (int k = 0; k < nb; k++) begin
            if (k > 0) begin
                chk("R9 random hold", scl_pull, 1);
                d = 8'($urandom_range(0, 255));
                stat_pulse();
                cpu_write(d);
            end
            m_byte_r(got);
            chk("R8 random tx data", got, d);
            m_bit_w((k == nb - 1) ? 1'b1 : 1'b0);
        end
        chk("R11 random end", addressed, 0);
        m_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic       ack, b;
        logic [7:0] v;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 reset scl_pull", scl_pull, 0);
        chk("R1 reset sda_pull", sda_pull, 0);
        chk("R1 reset flags", {addressed, txe, rxne, btf, ovr, udr}, 6'b010000);

        // R2: foreign address is NACKed and ignored
        m_start();
        m_byte_w({7'h33, 1'b0});
        m_bit_r(ack);
        chk("R2 mismatch nack", ack, 1);
        chk("R2 mismatch not addressed", addressed, 0);
        m_stop();

        // R2, R3, R4: master write of two bytes
        m_start();
        m_byte_w({OWN, 1'b0});
        m_bit_r(ack);
        chk("R2 match ack", ack, 0);
        chk("R3 write direction", is_tx, 0);
        m_byte_w(8'hA5);
        m_bit_r(ack);
        chk("R4 byte ack", ack, 0);
        chk("R4 rxne set", rxne, 1);
        cpu_read(v);
        chk("R4 read data", v, 8'hA5);
        chk("R4 rxne cleared", rxne, 0);
        m_stop();
        chk("R1 stop ends transfer", addressed, 0);

        // R5, R6: receive hold and ordered release
        stretch_en = 1'b1;
        m_start();
        m_byte_w({OWN, 1'b0});
        m_bit_r(ack);
        m_byte_w(8'h3C);
        m_bit_r(ack);
        m_byte_w(8'hC3);
        chk("R5 rx hold", scl_pull, 1);
        chk("R5 rx btf", btf, 1);
        cpu_read(v);
        chk("R6 bare read data", v, 8'h3C);
        repeat (4) @(negedge clk);
        chk("R6 bare read keeps hold", scl_pull, 1);
        stat_pulse();
        cpu_read(v);
        repeat (2) @(negedge clk);
        chk("R5 rx released", {scl_pull, btf}, 2'b00);
        m_bit_r(ack);
        chk("R5 held byte acked", ack, 0);
        chk("R5 held byte stored", rxne, 1);
        cpu_read(v);
        chk("R5 held byte data", v, 8'hC3);
        m_stop();

        // R7, R12: overrun without holding
        stretch_en = 1'b0;
        m_start();
        m_byte_w({OWN, 1'b0});
        m_bit_r(ack);
        m_byte_w(8'h11);
        m_bit_r(ack);
        m_byte_w(8'h22);
        chk("R7 no hold", scl_pull, 0);
        m_bit_r(ack);
        chk("R7 still acked", ack, 0);
        chk("R7 ovr set", ovr, 1);
        cpu_read(v);
        chk("R7 old byte kept", v, 8'h11);
        stat_pulse();
        chk("R12 ovr cleared", ovr, 0);
        m_stop();

        // R3, R8, R9, R6, R11: master read with hold on the second byte
        stretch_en = 1'b1;
        cpu_write(8'h96);
        chk("R8 txe cleared by write", txe, 0);
        m_start();
        m_byte_w({OWN, 1'b1});
        m_bit_r(ack);
        chk("R3 read direction", is_tx, 1);
        chk("R8 byte taken", txe, 1);
        m_byte_r(v);
        chk("R8 tx data", v, 8'h96);
        m_bit_w(1'b0);
        chk("R9 tx hold", scl_pull, 1);
        chk("R9 tx btf", btf, 1);
        cpu_write(8'h44);
        repeat (4) @(negedge clk);
        chk("R6 bare write keeps hold", scl_pull, 1);
        stat_pulse();
        cpu_write(8'h5E);
        repeat (2) @(negedge clk);
        chk("R9 tx released", scl_pull, 0);
        m_byte_r(v);
        chk("R9 written byte sent", v, 8'h5E);
        m_bit_w(1'b1);
        chk("R11 nack ends", addressed, 0);
        chk("R11 data released", sda_pull, 0);
        m_bit_r(b);
        m_bit_r(b);
        chk("R11 clocks ignored", b, 1);
        m_stop();

        // R10, R12: underrun resends previous byte
        stretch_en = 1'b0;
        cpu_write(8'h7B);
        m_start();
        m_byte_w({OWN, 1'b1});
        m_bit_r(ack);
        m_byte_r(v);
        chk("R10 first byte", v, 8'h7B);
        m_bit_w(1'b0);
        chk("R10 no hold", scl_pull, 0);
        chk("R10 udr set", udr, 1);
        m_byte_r(v);
        chk("R10 byte resent", v, 8'h7B);
        m_bit_w(1'b1);
        m_stop();
        stat_pulse();
        chk("R12 udr cleared", udr, 0);

        // R13: write during shift-out neither flagged nor applied mid-byte
        stretch_en = 1'b1;
        cpu_write(8'hD2);
        m_start();
        m_byte_w({OWN, 1'b1});
        m_bit_r(ack);
        for (int i = 7; i >= 5; i--) begin m_bit_r(b); v[i] = b; end
        cpu_write(8'h2D);
        for (int i = 4; i >= 0; i--) begin m_bit_r(b); v[i] = b; end
        chk("R13 current byte unchanged", v, 8'hD2);
        chk("R13 no flag", {ovr, udr}, 2'b00);
        chk("R13 write buffered", txe, 0);
        m_bit_w(1'b0);
        chk("R13 no hold", scl_pull, 0);
        m_byte_r(v);
        chk("R13 buffered byte sent", v, 8'h2D);
        m_bit_w(1'b1);
        m_stop();

        // Seeded random transfers in both directions
        for (int t = 0; t < 16; t++) begin
            if ($urandom_range(0, 1) == 0) rand_write();
            else                          rand_read();
        end

        summary();
    end
endmodule